// File: doc/BRIEF.md
# Multi-Mode Serial Bit-Rate Generator

This block derives the bit timing for one serial channel from the system clock. A single 8-bit reload value N sets the rate in all three operating modes: asynchronous, clocked synchronous and smart-card. A 2-bit prescaler select scales the rate by a power of four. In smart-card mode a 2-bit field picks how many basic clock cycles make up one bit, and one of those counts, 372, is not a power of two. Each channel instantiates its own copy, so channels run at independent rates.

The timing chain has three stages. A prescaler divides the clock by 1, 4, 16 or 64. A reload down-counter then produces a base tick every N+1 prescaled clocks. A mode divider turns base ticks into a one-cycle bit tick and a sampling tick, and in synchronous mode it also toggles a serial clock output. Software sets N and the control fields through a plain write port and reads them back through an address-selected port.

The block carries no data stream, so every pin is a plain control or status pin. There is no valid/ready handshake and nothing that can apply back-pressure. A write is accepted in the cycle where `wr_en` is high.

Top module: `baud_timer`

## Requirements
- R1: After reset, reading address 0 returns 0xFF (N) and reading address 1 returns 0x00. Either register can be read at any time through `rd_addr`/`rd_data`.
- R2: The control register at address 1 has these fields: bits [1:0] are the prescaler select n, bits [3:2] are the card cycle select, bits [5:4] are the mode (00 asynchronous, 01 synchronous, 10 smart-card, 11 treated as asynchronous). Bits [7:6] always read as 0.
- R3: The prescaler divides the clock by 4^n, so encodings 00, 01, 10 and 11 give 1, 4, 16 and 64.
- R4: In asynchronous mode, consecutive `bit_tick` pulses are 32 x 4^n x (N+1) clocks apart, and each pulse lasts one cycle.
- R5: In synchronous mode, consecutive `bit_tick` pulses are 4 x 4^n x (N+1) clocks apart.
- R6: In smart-card mode, consecutive `bit_tick` pulses are 2 x S x 4^n x (N+1) clocks apart. S is 32, 64, 372 or 256 for card select encodings 00, 01, 10 and 11.
- R7: `samp_tick` fires once every two base ticks. That gives 16 pulses per bit in asynchronous mode, 2 in synchronous mode and S in smart-card mode, and every `bit_tick` coincides with a `samp_tick`.
- R8: In synchronous mode, `sclk_out` toggles on each `samp_tick`, giving one full cycle per bit. It is low after any restart and stays low in every other mode.
- R9: Any register write restarts all counters. No `bit_tick` occurs in the cycle after the write edge. The first `bit_tick` falls exactly one bit period after that edge.
- R10: Mode encoding 11 produces the same timing as asynchronous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 selects N, 1 selects control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address |
| rd_data | output | 8 | Readback of the addressed register |
| bit_tick | output | 1 | One-cycle pulse at each bit boundary |
| samp_tick | output | 1 | One-cycle sampling (basic clock) pulse |
| sclk_out | output | 1 | Serial clock, active in synchronous mode |

## Verification
The assertions assume that the configuration changes only through the write port. They also assume that every write restarts the chain, so no property has to tolerate a divider limit that shifts in mid-count. The stimulus therefore issues each case as two writes, first N and then control, and starts measuring only after the second write. Random cases cap N and the prescaler so that each bit period stays within a few thousand clocks. The largest settings appear only in directed cases whose period is known to fit in the run.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    MODE_ASYNC = 2'b00,
    MODE_SYNC  = 2'b01,
    MODE_CARD  = 2'b10,
    MODE_RSVD  = 2'b11
  } mode_e;

  localparam int unsigned SEL_W = 2;
  localparam int unsigned DIV_W = 10;
  localparam int unsigned ASYNC_DIV = 32;
  localparam int unsigned SYNC_DIV  = 4;

  function automatic int unsigned card_cycles(input logic [SEL_W-1:0] sel);
    case (sel)
      2'b00:   card_cycles = 32;
      2'b01:   card_cycles = 64;
      2'b10:   card_cycles = 372;
      default: card_cycles = 256;
    endcase
  endfunction
endpackage

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int unsigned PRE_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       pre_tick
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] limit;

  always_comb begin
    case (sel)
      2'b00:   limit = PRE_W'(0);
      2'b01:   limit = PRE_W'(3);
      2'b10:   limit = PRE_W'(15);
      default: limit = PRE_W'(63);
    endcase
  end

  assign pre_tick = (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt_q <= '0;
    else if (pre_tick)     cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/baud_reload.sv
module baud_reload #(
  parameter int unsigned RATE_W = 8,
  parameter logic [RATE_W-1:0] RATE_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [RATE_W-1:0] start_val,
  input  logic [RATE_W-1:0] rate,
  input  logic              pre_tick,
  output logic              base_tick
);
  logic [RATE_W-1:0] cnt_q;

  assign base_tick = pre_tick && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= RATE_RST;
    else if (restart)   cnt_q <= start_val;
    else if (base_tick) cnt_q <= rate;
    else if (pre_tick)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/baud_modediv.sv
module baud_modediv
  import baud_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        base_tick,
  input  logic [1:0]  mode,
  input  logic [1:0]  card_sel,
  output logic        bit_tick,
  output logic        samp_tick,
  output logic        sclk_out
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] limit;
  logic             sclk_q;

  always_comb begin
    case (mode_e'(mode))
      MODE_SYNC: limit = DIV_W'(SYNC_DIV - 1);
      MODE_CARD: limit = DIV_W'(2 * card_cycles(card_sel) - 1);
      default:   limit = DIV_W'(ASYNC_DIV - 1);
    endcase
  end

  assign bit_tick  = base_tick && (cnt_q == limit);
  assign samp_tick = base_tick && cnt_q[0];
  assign sclk_out  = sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt_q <= '0;
    else if (bit_tick)     cnt_q <= '0;
    else if (base_tick)    cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart)          sclk_q <= 1'b0;
    else if (mode != MODE_SYNC)     sclk_q <= 1'b0;
    else if (samp_tick)             sclk_q <= ~sclk_q;
  end
endmodule

// File: rtl/baud_timer.sv
module baud_timer
  import baud_pkg::*;
#(
  parameter int unsigned RATE_W = 8,
  parameter logic [RATE_W-1:0] RATE_RST = '1,
  parameter int unsigned PRE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [RATE_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [RATE_W-1:0] rd_data,
  output logic              bit_tick,
  output logic              samp_tick,
  output logic              sclk_out
);
  logic [RATE_W-1:0] rate_q;
  logic [1:0]        presc_q;
  logic [1:0]        card_q;
  logic [1:0]        mode_q;
  logic [RATE_W-1:0] start_val;
  logic              pre_tick;
  logic              base_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q  <= RATE_RST;
      presc_q <= '0;
      card_q  <= '0;
      mode_q  <= MODE_ASYNC;
    end else if (wr_en) begin
      if (!wr_addr) rate_q <= wr_data;
      else begin
        presc_q <= wr_data[1:0];
        card_q  <= wr_data[3:2];
        mode_q  <= wr_data[5:4];
      end
    end
  end

  assign start_val = (wr_en && !wr_addr) ? wr_data : rate_q;

  always_comb begin
    rd_data = '0;
    if (!rd_addr) rd_data = rate_q;
    else          rd_data[5:0] = {mode_q, card_q, presc_q};
  end

  baud_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(wr_en), .sel(presc_q), .pre_tick(pre_tick)
  );

  baud_reload #(.RATE_W(RATE_W), .RATE_RST(RATE_RST)) u_rel (
    .clk(clk), .rst_n(rst_n), .restart(wr_en), .start_val(start_val),
    .rate(rate_q), .pre_tick(pre_tick), .base_tick(base_tick)
  );

  baud_modediv u_div (
    .clk(clk), .rst_n(rst_n), .restart(wr_en), .base_tick(base_tick),
    .mode(mode_q), .card_sel(card_q), .bit_tick(bit_tick),
    .samp_tick(samp_tick), .sclk_out(sclk_out)
  );
endmodule

// File: rtl/baud_timer_chk.sv
module baud_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       bit_tick,
  input logic       samp_tick,
  input logic       sclk_out,
  input logic       base_tick,
  input logic [1:0] mode_q
);
  // R4, R5, R6: bit boundaries fall only on base ticks
  assert_bit_on_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> base_tick);

  // R7: every bit tick is also a sampling tick
  assert_bit_with_samp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> samp_tick);

  // R7: sampling ticks come from base ticks
  assert_samp_on_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
    samp_tick |-> base_tick);

  // R8: serial clock is idle low outside synchronous mode
  assert_sclk_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'b01) |-> !sclk_out);

  // R8: serial clock moves only on a sampling tick
  assert_sclk_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!samp_tick && !wr_en) |=> $stable(sclk_out));

  // R9: a write is never followed directly by a bit tick
  assert_no_tick_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !bit_tick);
endmodule

bind baud_timer baud_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bit_tick(bit_tick),
  .samp_tick(samp_tick), .sclk_out(sclk_out), .base_tick(base_tick),
  .mode_q(mode_q)
);

// File: tb/baud_timer_bench.sv
module baud_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic       bit_tick, samp_tick, sclk_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_timer u_baud_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .bit_tick(bit_tick), .samp_tick(samp_tick), .sclk_out(sclk_out)
  );

  function automatic int card_s(input int sel);
    case (sel)
      0: return 32;
      1: return 64;
      2: return 372;
      default: return 256;
    endcase
  endfunction

  function automatic int mode_div(input int mode, input int csel);
    if (mode == 1) return 4;
    if (mode == 2) return 2 * card_s(csel);
    return 32;
  endfunction

  function automatic int exp_period(input int rate, input int presc, input int csel, input int mode);
    return mode_div(mode, csel) * (1 << (2 * presc)) * (rate + 1);
  endfunction

  function automatic int exp_samps(input int mode, input int csel);
    return mode_div(mode, csel) / 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input bit addr, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_case(input int rate, input int presc, input int csel, input int mode, input string req);
    int t_exp, c, t1, t2, samps, toggles;
    logic prev_sclk;
    t_exp = exp_period(rate, presc, csel, mode);
    write_reg(1'b0, 8'(rate));
    write_reg(1'b1, 8'({mode[1:0], csel[1:0], presc[1:0]}));
    rd_addr = 1'b0; #1;
    check(rd_data == 8'(rate), "R1 readback N", rd_data, rate);
    check(bit_tick == 1'b0, "R9 no tick after write", bit_tick, 0);
    check(sclk_out == 1'b0, "R8 sclk low after restart", sclk_out, 0);
    c = 1; t1 = 0; t2 = 0; samps = 0; toggles = 0; prev_sclk = sclk_out;
    while (c <= 2 * t_exp + 4 && t2 == 0) begin
      if (t1 != 0 && samp_tick) samps++;
      if (t1 != 0 && sclk_out != prev_sclk) toggles++;
      prev_sclk = sclk_out;
      if (bit_tick) begin
        if (t1 == 0) t1 = c; else t2 = c;
      end
      @(negedge clk); c++;
    end
    check(t1 == t_exp, "R9 first tick one period after write", t1, t_exp);
    check(t2 - t1 == t_exp, req, t2 - t1, t_exp);
    check(samps == exp_samps(mode, csel), "R7 samples per bit", samps, exp_samps(mode, csel));
    check(toggles == (mode == 1 ? 2 : 0), "R8 sclk toggles per bit", toggles, (mode == 1 ? 2 : 0));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int r, p, s, m, dummy;
    dummy = $urandom(42);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_addr = 1'b0; #1;
    check(rd_data == 8'hFF, "R1 reset N", rd_data, 8'hFF);
    rd_addr = 1'b1; #1;
    check(rd_data == 8'h00, "R1 reset control", rd_data, 0);
    check(bit_tick == 1'b0, "R4 no tick at reset", bit_tick, 0);

    write_reg(1'b1, 8'hFF);
    rd_addr = 1'b1; #1;
    check(rd_data == 8'h3F, "R2 control field mask", rd_data, 8'h3F);

    run_case(0,   0, 0, 0, "R4 async N=0 n=0");
    run_case(255, 0, 0, 0, "R4 async N=255 n=0");
    run_case(1,   3, 0, 0, "R3 async n=3 prescale 64");
    run_case(2,   1, 0, 0, "R3 async n=1 prescale 4");
    run_case(0,   0, 0, 1, "R5 sync N=0");
    run_case(255, 0, 0, 1, "R5 sync N=255");
    run_case(3,   2, 0, 1, "R5 sync n=2");
    run_case(0,   0, 2, 2, "R6 card S=372");
    run_case(1,   1, 3, 2, "R6 card S=256 n=1");
    run_case(2,   0, 1, 2, "R6 card S=64");
    run_case(4,   0, 0, 2, "R6 card S=32");
    run_case(5,   1, 0, 3, "R10 reserved mode as async");

    for (int i = 0; i < 10; i++) begin
      r = int'($urandom % 256); p = int'($urandom % 4);
      s = int'($urandom % 4);   m = int'($urandom % 4);
      if (exp_period(r, p, s, m) > 4000) begin
        p = 0; r = r % 4;
      end
      run_case(r, p, s, m, "R4 R5 R6 random period");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule